// File: doc/BRIEF.md
# Bidirectional GPIO Port with Per-Bit Direction Control

This block is a general-purpose I/O port of `WIDTH` pins (eight by default), reached through a small register bus with two locations. One location holds output data. The other holds a direction mask. Each pin is set up on its own, as an input or as an output. The pads are presented as three vectors: the value to drive, a per-bit output enable, and the sampled pad level.

A direction bit of one turns its pin into an output, and the output latch then drives that pin. A direction bit of zero releases the pin, which is then tri-stated. Reading the data location gives a merged word:

- bits set as outputs return the latched value;
- bits set as inputs return the live pad level, with no sampling register in the path.

Reset clears only the direction mask, so every pin becomes an input. The output latch is left as it was. Software can therefore preload output values before it turns any pin into an output.

Top module: `gpio_port`

## Requirements
- R1: While `rst_n` is low, and directly after it rises, the direction mask reads back as zero and `pad_oe` is all zeros.
- R2: A bus write (`bus_sel`=1, `bus_wr`=1) to offset 1 (`bus_addr`=1) loads `bus_wdata` into the direction mask at that clock edge. A read of offset 1 returns the mask.
- R3: `pad_oe[i]` equals direction bit i at all times. A 1 in the mask means output and a 0 means input.
- R4: A bus write to offset 0 loads the output latch. Every bit whose direction bit is 1 drives the latched value on `pad_out`.
- R5: While `bus_addr`=0, `bus_rdata[i]` is latch bit i when direction bit i is 1. It is `pad_in[i]` in the same cycle, unregistered, when direction bit i is 0.
- R6: A write to offset 0 updates the latch whatever the direction bits are. A value written while a pin is an input appears on the pin once it is made an output.
- R7: Reset does not change the output latch.
- R8: A cycle with `bus_sel`=0 or `bus_wr`=0 changes neither register.
- R9: A write becomes visible only after the clock edge that samples it. Before that edge, the outputs still show the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset (clears direction only) |
| bus_sel | input | 1 | Bus access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 1 | 0 = data register, 1 = direction register |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Read data for the addressed register (combinational) |
| pad_out | output | WIDTH | Value driven toward the pads |
| pad_oe | output | WIDTH | Per-bit output enable |
| pad_in | input | WIDTH | Live pad levels |

## Verification
The bench preloads the latch, resets the block and then enables the outputs. A design that reset the latch would show zeros on the pads instead of the preloaded value.

It also writes data while the pins are inputs and then turns them into outputs. A design that gated latch writes by direction would drive stale bits.

With mixed direction masks it changes `pad_in` in the same cycle as a read. A registered input path would return the value from one cycle earlier. A swapped merge would return latch bits where pin levels are expected.

Finally, it checks the outputs just before and just after a write edge, and it applies strobes with only one of select and write raised. A design with a write-through path, or with loose strobe qualification, changes the outputs at the wrong moment.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

   // Register offsets on the one-bit bus address.
   typedef enum logic {
      OFS_DATA = 1'b0,
      OFS_DIR  = 1'b1
   } gpio_ofs_e;

   localparam int MAX_WIDTH = 64;

endpackage

// File: rtl/gpio_dir_reg.sv
module gpio_dir_reg #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dir
);
   // Direction mask: the only state touched by reset.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         dir <= '0;
      else if (load)
         dir <= din;
   end
endmodule

// File: rtl/gpio_out_latch.sv
module gpio_out_latch #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             load,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] q
);
   // No reset on purpose: contents survive a reset pulse.
   always_ff @(posedge clk) begin
      if (load)
         q <= din;
   end
endmodule

// File: rtl/gpio_bit_slice.sv
module gpio_bit_slice (
   input  logic is_out,
   input  logic latch_bit,
   input  logic pin_bit,
   output logic drv_val,
   output logic drv_en,
   output logic rd_bit
);
   assign drv_val = latch_bit;
   assign drv_en  = is_out;
   // Input bits come straight from the pin, with no register in the path.
   assign rd_bit  = is_out ? latch_bit : pin_bit;
endmodule

// File: rtl/gpio_port.sv
module gpio_port #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_sel,
   input  logic             bus_wr,
   input  logic             bus_addr,
   input  logic [WIDTH-1:0] bus_wdata,
   output logic [WIDTH-1:0] bus_rdata,
   output logic [WIDTH-1:0] pad_out,
   output logic [WIDTH-1:0] pad_oe,
   input  logic [WIDTH-1:0] pad_in
);
   import gpio_port_pkg::*;

   localparam int LAST = WIDTH - 1;

   generate
      if (WIDTH < 1 || WIDTH > MAX_WIDTH) begin : g_bad_width
         $error("gpio_port: WIDTH out of range");
      end
   endgenerate

   logic             wr_qual;
   logic             ld_data;
   logic             ld_dir;
   logic [LAST:0]    dir_q;
   logic [LAST:0]    lat_q;
   logic [LAST:0]    merged;

   assign wr_qual = bus_sel & bus_wr;
   assign ld_data = wr_qual & (gpio_ofs_e'(bus_addr) == OFS_DATA);
   assign ld_dir  = wr_qual & (gpio_ofs_e'(bus_addr) == OFS_DIR);

   gpio_dir_reg #(.WIDTH(WIDTH)) u_dir (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (ld_dir),
      .din   (bus_wdata),
      .dir   (dir_q)
   );

   gpio_out_latch #(.WIDTH(WIDTH)) u_lat (
      .clk  (clk),
      .load (ld_data),
      .din  (bus_wdata),
      .q    (lat_q)
   );

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      gpio_bit_slice u_slice (
         .is_out    (dir_q[i]),
         .latch_bit (lat_q[i]),
         .pin_bit   (pad_in[i]),
         .drv_val   (pad_out[i]),
         .drv_en    (pad_oe[i]),
         .rd_bit    (merged[i])
      );
   end

   always_comb begin
      unique case (gpio_ofs_e'(bus_addr))
         OFS_DATA: bus_rdata = merged;
         OFS_DIR:  bus_rdata = dir_q;
         default:  bus_rdata = '0;
      endcase
   end
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
   parameter int WIDTH = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             bus_sel,
   input logic             bus_wr,
   input logic             bus_addr,
   input logic [WIDTH-1:0] bus_wdata,
   input logic [WIDTH-1:0] bus_rdata,
   input logic [WIDTH-1:0] pad_out,
   input logic [WIDTH-1:0] pad_oe,
   input logic [WIDTH-1:0] pad_in
);
   // R1: no pin is enabled while reset is held
   a_r1_reset_inputs: assert property (@(posedge clk)
      !rst_n |-> pad_oe == '0);

   // R2 / R3: a direction write shows on the enables one edge later
   a_r2_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && bus_addr) |=> pad_oe == $past(bus_wdata));

   // R2: offset 1 reads back the mask that drives the enables
   a_r2_dir_readback: assert property (@(posedge clk) disable iff (!rst_n)
      bus_addr |-> bus_rdata == pad_oe);

   // R4: a data write appears on pad_out one edge later
   a_r4_data_write: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && !bus_addr) |=> pad_out == $past(bus_wdata));

   // R5: merge of latch and live pin levels on a data read
   a_r5_merge: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_addr |-> (((bus_rdata ^ pad_out) & pad_oe) == '0 &&
                     ((bus_rdata ^ pad_in) & ~pad_oe) == '0));

   // R8: without a qualified write both registers hold
   a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_sel && bus_wr) |=> ($stable(pad_oe) && $stable(pad_out)));
endmodule

bind gpio_port gpio_port_chk #(.WIDTH(WIDTH)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_sel   (bus_sel),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .pad_out   (pad_out),
   .pad_oe    (pad_oe),
   .pad_in    (pad_in)
);

// File: tb/gpio_port_test.sv
module gpio_port_test;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         bus_sel = 1'b0;
   logic         bus_wr = 1'b0;
   logic         bus_addr = 1'b0;
   logic [W-1:0] bus_wdata = '0;
   logic [W-1:0] pad_in = '0;
   logic [W-1:0] bus_rdata;
   logic [W-1:0] pad_out;
   logic [W-1:0] pad_oe;

   int  n_chk = 0;
   int  n_bad = 0;
   bit  done = 1'b0;

   always #4 clk = ~clk;

   gpio_port #(.WIDTH(W)) uut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pad_out(pad_out), .pad_oe(pad_oe), .pad_in(pad_in)
   );

   // Behavioural reference model
   logic [W-1:0] m_dir = '0;
   logic [W-1:0] m_lat = '0;
   logic [W-1:0] m_known = '0;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         m_dir <= '0;
      else if (bus_sel && bus_wr) begin
         if (bus_addr) m_dir <= bus_wdata;
         else begin
            m_lat   <= bus_wdata;
            m_known <= '1;
         end
      end
   end

   task automatic chk(string req, logic [W-1:0] got, logic [W-1:0] exp,
                      logic [W-1:0] mask);
      n_chk++;
      if (((got ^ exp) & mask) != '0) begin
         n_bad++;
         $display("FAIL %s got %h expected %h (mask %h) at %0t",
                  req, got, exp, mask, $time);
      end
   endtask

   // Per-cycle comparison against the model, away from the rising edge
   always begin
      @(negedge clk);
      #2;
      if (!done) begin
         chk("R3 pad_oe", pad_oe, m_dir, '1);
         chk("R4 pad_out", pad_out, m_lat, m_dir & m_known);
         if (bus_addr)
            chk("R2 dir readback", bus_rdata, m_dir, '1);
         else
            chk("R5 merged read", bus_rdata,
                (m_dir & m_lat) | (~m_dir & pad_in), ~m_dir | m_known);
      end
   end

   task automatic wr(input logic a, input logic [W-1:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic rd(input logic a, output logic [W-1:0] d);
      @(negedge clk);
      bus_addr = a;
      #3;
      d = bus_rdata;
   endtask

   initial begin
      logic [W-1:0] v;
      repeat (3) @(negedge clk);
      chk("R1 oe in reset", pad_oe, '0, '1);
      rst_n = 1'b1;

      rd(1'b1, v);
      chk("R1 dir after reset", v, '0, '1);

      wr(1'b0, 8'hA5);
      wr(1'b1, 8'h0F);
      rd(1'b1, v);
      chk("R2 dir readback", v, 8'h0F, '1);
      chk("R4 drive low nibble", pad_out, 8'h05, 8'h0F);

      @(negedge clk); pad_in = 8'h3C;
      rd(1'b0, v);
      chk("R5 mixed read", v, 8'h35, '1);
      @(negedge clk); bus_addr = 1'b0; pad_in = 8'hC3; #2;
      chk("R5 live pin same cycle", bus_rdata, 8'hC5, '1);

      // R6: write while pins are inputs, then enable them
      wr(1'b0, 8'h96);
      wr(1'b1, 8'hFF);
      chk("R6 preloaded drive", pad_out, 8'h96, '1);

      // R8: half-qualified strobes
      @(negedge clk); bus_sel = 1'b0; bus_wr = 1'b1; bus_addr = 1'b0; bus_wdata = 8'h00;
      @(negedge clk); bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 1'b1;
      @(negedge clk); bus_sel = 1'b0; #2;
      chk("R8 latch held", pad_out, 8'h96, '1);
      chk("R8 dir held", pad_oe, 8'hFF, '1);

      // R9: timing of a write relative to the edge
      @(negedge clk); bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 1'b0; bus_wdata = 8'h11;
      #2;
      chk("R9 before edge", pad_out, 8'h96, '1);
      @(posedge clk); #1;
      chk("R9 after edge", pad_out, 8'h11, '1);
      @(negedge clk); bus_sel = 1'b0; bus_wr = 1'b0;

      // R7: reset leaves the latch alone
      wr(1'b0, 8'hC3);
      @(negedge clk); rst_n = 1'b0; #2;
      chk("R1 oe cleared by reset", pad_oe, '0, '1);
      @(negedge clk); rst_n = 1'b1;
      wr(1'b1, 8'hFF);
      chk("R7 latch kept", pad_out, 8'hC3, '1);

      // Sweep direction masks against changing pin levels
      for (int k = 0; k < 16; k++) begin
         wr(1'b1, 8'(k * 37));
         @(negedge clk); pad_in = 8'(k * 91 + 5); bus_addr = 1'b0;
         @(negedge clk); pad_in = ~pad_in;
      end

      @(negedge clk); #3;
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      #(8 * 20000);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule